// File: doc/BRIEF.md
# Two-Operand Pair Fusion Decoder

This decoder feeds a three-operand execution engine from an instruction stream in which every instruction is 16 bits wide and names only two registers. Each cycle it takes a 32-bit window of two consecutive instructions and produces one micro-operation. The micro-operation carries an operation code, two source registers, a destination register, the number of instructions it used up (1 or 2), and a fused flag.

The compact format costs an extra instruction whenever a result must not overwrite an operand: a copy first, then the arithmetic. The decoder spots a register copy followed directly by an ALU instruction that writes the copy's target. It issues that pair as one three-operand operation, so the pair costs one issue slot instead of two. In every other case it decodes only the older instruction. Fetch realignment uses the consumed count.

Input and output are valid/ready streams with a single registered output stage. A window is accepted when `in_valid` and `in_ready` are both high. While `out_valid` is high and `out_ready` is low, the output holds and `in_ready` is low. `in_ready` is high whenever the output register is empty or is being drained in the same cycle.

Top module: `fuse_decoder`

## Requirements
- R1: Instruction fields. Bits [15:12] hold the opcode, [11:8] the source register, [7:4] the accumulator/destination register, and [3:0] must be zero. The older instruction is in `in_window[15:0]` and the younger one in `in_window[31:16]`.
- R2: A single ALU instruction (opcode 2 to 6: add, sub, and, or, xor) with fields B and C issues as opcode unchanged, src_a = C, src_b = B, dst = C, consumed 1, fused 0.
- R3: A single move (opcode 1) with fields A and C issues as opcode 1, src_a = A, src_b = 0, dst = C, consumed 1, fused 0.
- R4: A move A→C followed by an ALU instruction whose destination field equals C issues as the ALU opcode with src_a = A, src_b = B, dst = C, consumed 2, fused 1.
- R5: In a fused pair whose ALU source field equals C, src_b is A instead of C.
- R6: No fusion happens when the older instruction is not a move, when the younger one is not an ALU opcode, or when the two destination fields differ. Only the older instruction is consumed.
- R7: When `in_hi_valid` is low, no fusion happens, whatever the younger half holds.
- R8: When either half has nonzero bits [3:0], no fusion happens. The older instruction is still decoded by its opcode.
- R9: Any opcode other than 1 to 6 issues unchanged with src_a = source field, src_b = destination field, dst = destination field, consumed 1, fused 0.
- R10: While `out_valid` is high and `out_ready` is low, every output field stays stable and `in_ready` is low.
- R11: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Window valid |
| in_ready | output | 1 | Decoder can accept a window |
| in_window | input | 32 | Two instructions, older in the low half |
| in_hi_valid | input | 1 | Younger half holds a real instruction |
| out_valid | output | 1 | Micro-operation valid |
| out_ready | input | 1 | Consumer takes the micro-operation |
| out_opcode | output | 4 | Operation code |
| out_src_a | output | 4 | First source register |
| out_src_b | output | 4 | Second source register |
| out_dst | output | 4 | Destination register |
| out_consumed | output | 2 | Instructions used up (1 or 2) |
| out_fused | output | 1 | Pair was fused |

## Verification
The assertions check several properties on every cycle. They check that the output holds under back-pressure and that the input stalls while it does. They check that an accepted window with an invalid younger half never yields a fused result, and that a well-formed move/ALU pair with matching destinations always fuses into the move's destination. They also check that the consumed count agrees with the fused flag, and that an aliased fused operand resolves to the move source. Only the bench scenarios show the exact field mapping for every opcode class, the alias substitution values, rejection of malformed halves, and correct ordering of results across random stalls.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam int INSN_W = 16;
  localparam int OP_W   = 4;
  localparam int REG_W  = 4;
  localparam int PAD_W  = INSN_W - OP_W - 2 * REG_W;
  localparam int CNT_W  = 2;

  localparam logic [OP_W-1:0] OP_MOV    = 4'h1;
  localparam logic [OP_W-1:0] OP_ALU_LO = 4'h2;
  localparam logic [OP_W-1:0] OP_ALU_HI = 4'h6;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [REG_W-1:0] rs;
    logic [REG_W-1:0] rd;
    logic             clean;
    logic             is_mov;
    logic             is_alu;
  } insn_f_t;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [REG_W-1:0] src_a;
    logic [REG_W-1:0] src_b;
    logic [REG_W-1:0] dst;
    logic [CNT_W-1:0] consumed;
    logic             fused;
  } uop_t;
endpackage

// File: rtl/fuse_field_split.sv
module fuse_field_split
  import fuse_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output insn_f_t           f
);
  always_comb begin
    f.op     = insn[INSN_W-1 -: OP_W];
    f.rs     = insn[INSN_W-OP_W-1 -: REG_W];
    f.rd     = insn[INSN_W-OP_W-REG_W-1 -: REG_W];
    f.clean  = (insn[PAD_W-1:0] == '0);
    f.is_mov = (f.op == OP_MOV);
    f.is_alu = (f.op >= OP_ALU_LO) && (f.op <= OP_ALU_HI);
  end
endmodule

// File: rtl/fuse_pair_merge.sv
module fuse_pair_merge
  import fuse_pkg::*;
(
  input  insn_f_t older,
  input  insn_f_t younger,
  input  logic    younger_ok,
  output uop_t    uop
);
  logic can_fuse;
  logic alias_hit;

  always_comb begin
    can_fuse  = younger_ok && older.clean && younger.clean &&
                older.is_mov && younger.is_alu && (younger.rd == older.rd);
    alias_hit = (younger.rs == older.rd);

    uop = '0;
    if (can_fuse) begin
      uop.op       = younger.op;
      uop.src_a    = older.rs;
      uop.src_b    = alias_hit ? older.rs : younger.rs;
      uop.dst      = older.rd;
      uop.consumed = CNT_W'(2);
      uop.fused    = 1'b1;
    end else if (older.is_mov) begin
      uop.op       = older.op;
      uop.src_a    = older.rs;
      uop.src_b    = '0;
      uop.dst      = older.rd;
      uop.consumed = CNT_W'(1);
    end else if (older.is_alu) begin
      uop.op       = older.op;
      uop.src_a    = older.rd;
      uop.src_b    = older.rs;
      uop.dst      = older.rd;
      uop.consumed = CNT_W'(1);
    end else begin
      uop.op       = older.op;
      uop.src_a    = older.rs;
      uop.src_b    = older.rd;
      uop.dst      = older.rd;
      uop.consumed = CNT_W'(1);
    end
  end
endmodule

// File: rtl/fuse_out_reg.sv
module fuse_out_reg
  import fuse_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  uop_t d,
  output logic out_valid,
  input  logic out_ready,
  output uop_t q
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q         <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) q <= d;
    end
  end
endmodule

// File: rtl/fuse_decoder.sv
module fuse_decoder
  import fuse_pkg::*;
#(
  parameter int SLOTS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_window,
  input  logic        in_hi_valid,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [3:0]  out_opcode,
  output logic [3:0]  out_src_a,
  output logic [3:0]  out_src_b,
  output logic [3:0]  out_dst,
  output logic [1:0]  out_consumed,
  output logic        out_fused
);
  localparam int WIN_W = SLOTS * INSN_W;

  insn_f_t fields [SLOTS];
  uop_t    next_uop;
  uop_t    held_uop;
  logic [WIN_W-1:0] win;

  assign win = in_window[WIN_W-1:0];

  for (genvar s = 0; s < SLOTS; s++) begin : g_split
    fuse_field_split u_split (
      .insn (win[s*INSN_W +: INSN_W]),
      .f    (fields[s])
    );
  end

  fuse_pair_merge u_merge (
    .older      (fields[0]),
    .younger    (fields[1]),
    .younger_ok (in_hi_valid),
    .uop        (next_uop)
  );

  fuse_out_reg u_oreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d         (next_uop),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .q         (held_uop)
  );

  assign out_opcode   = held_uop.op;
  assign out_src_a    = held_uop.src_a;
  assign out_src_b    = held_uop.src_b;
  assign out_dst      = held_uop.dst;
  assign out_consumed = held_uop.consumed;
  assign out_fused    = held_uop.fused;
endmodule

// File: rtl/fuse_decoder_chk.sv
module fuse_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] in_window,
  input logic        in_hi_valid,
  input logic        out_valid,
  input logic        out_ready,
  input logic [3:0]  out_opcode,
  input logic [3:0]  out_src_a,
  input logic [3:0]  out_src_b,
  input logic [3:0]  out_dst,
  input logic [1:0]  out_consumed,
  input logic        out_fused
);
  logic pair_ok;
  assign pair_ok = in_hi_valid && (in_window[15:12] == 4'h1) &&
                   (in_window[31:28] >= 4'h2) && (in_window[31:28] <= 4'h6) &&
                   (in_window[23:20] == in_window[7:4]) &&
                   (in_window[3:0] == 4'h0) && (in_window[19:16] == 4'h0);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid &&
      $stable({out_opcode, out_src_a, out_src_b, out_dst, out_consumed, out_fused}));

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_hi_invalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_hi_valid |=> !out_fused);

  assert_fuse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && pair_ok |=>
      out_valid && out_fused && out_consumed == 2'd2 && out_dst == $past(in_window[7:4]));

  assert_alias_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fused && out_src_b == out_dst |-> out_src_a == out_dst);

  assert_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_consumed == (out_fused ? 2'd2 : 2'd1));
endmodule

bind fuse_decoder fuse_decoder_chk u_chk (.*);

// File: tb/fuse_decoder_tb.sv
module fuse_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_window = '0;
  logic        in_hi_valid = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [3:0]  out_opcode, out_src_a, out_src_b, out_dst;
  logic [1:0]  out_consumed;
  logic        out_fused;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [18:0] exp_q[$];
  string       tag_q[$];
  logic        stalled = 1'b0;
  logic [18:0] stall_val;

  always #10 clk = ~clk;

  fuse_decoder u_dut (.*);

  // Expected {op, src_a, src_b, dst, consumed, fused}
  function automatic logic [18:0] model(input logic [31:0] w, input logic hv);
    logic [3:0] o0, a0, c0, o1, b1, c1;
    logic ok0, ok1, alu1;
    o0 = w[15:12]; a0 = w[11:8]; c0 = w[7:4]; ok0 = (w[3:0] == 0);
    o1 = w[31:28]; b1 = w[27:24]; c1 = w[23:20]; ok1 = (w[19:16] == 0);
    alu1 = (o1 >= 2 && o1 <= 6);
    if (hv && ok0 && ok1 && o0 == 1 && alu1 && c1 == c0)
      return {o1, a0, (b1 == c0) ? a0 : b1, c0, 2'd2, 1'b1};
    if (o0 == 1) return {o0, a0, 4'd0, c0, 2'd1, 1'b0};
    if (o0 >= 2 && o0 <= 6) return {o0, c0, a0, c0, 2'd1, 1'b0};
    return {o0, a0, c0, c0, 2'd1, 1'b0};
  endfunction

  function automatic string auto_tag(input logic [31:0] w, input logic [18:0] e);
    if (e[0]) return (w[27:24] == w[7:4]) ? "R5" : "R4";
    if (w[15:12] == 1) return "R3";
    if (w[15:12] >= 2 && w[15:12] <= 6) return "R2";
    return "R9";
  endfunction

  function automatic logic [15:0] ins(input logic [3:0] o, input logic [3:0] s,
                                      input logic [3:0] d);
    return {o, s, d, 4'h0};
  endfunction

  function automatic logic [18:0] outs();
    return {out_opcode, out_src_a, out_src_b, out_dst, out_consumed, out_fused};
  endfunction

  task automatic check(input string tag, input logic [18:0] act, input logic [18:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] w, input logic hv,
                      input logic rdy, input string tag);
    @(negedge clk);
    if (stalled) check("R10", {out_valid, outs()}, {1'b1, stall_val});
    in_valid = v; in_window = w; in_hi_valid = hv; out_ready = rdy;
    #1;
    if (out_valid && out_valid == 1'b1 && !out_ready) begin
      checks++;
      if (in_ready !== 1'b0) begin
        errors++;
        $display("FAIL R10: actual in_ready %b expected 0", in_ready);
      end
    end
    stalled = out_valid && !out_ready;
    stall_val = outs();
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check("R10", 19'h1, 19'h0);
      else check(tag_q.pop_front(), outs(), exp_q.pop_front());
    end
    if (v && in_ready) begin
      logic [18:0] e;
      e = model(w, hv);
      exp_q.push_back(e);
      tag_q.push_back(tag == "" ? auto_tag(w, e) : tag);
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b0, 1'b1, "");
  endtask

  function automatic logic [31:0] rand_window();
    logic [3:0] a, b, c, o;
    int k;
    a = 4'($urandom); b = 4'($urandom); c = 4'($urandom);
    o = 4'($urandom_range(2, 6));
    k = $urandom_range(0, 9);
    case (k)
      0, 1, 2: return {ins(o, b, c), ins(4'h1, a, c)};
      3:       return {ins(o, c, c), ins(4'h1, a, c)};
      4:       return {ins(o, b, c ^ 4'h3), ins(4'h1, a, c)};
      5:       return {ins(o, b, c), ins(o, a, c)};
      6:       return {ins(4'($urandom_range(7, 15)), b, c), ins(4'h1, a, c)};
      7:       return {ins(o, b, c), ins(4'h1, a, c) | 16'($urandom_range(1, 15))};
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    #1;
    check("R11", {17'h0, out_valid, in_ready}, {17'h0, 1'b0, 1'b1});
    rst_n = 1'b1;

    // R1/R4 fields: mov r3->r7, add r5,r7 => r7 = r3 + r5
    step(1'b1, {ins(4'h2, 4'h5, 4'h7), ins(4'h1, 4'h3, 4'h7)}, 1'b1, 1'b1, "R4");
    // R5 alias: mov r2->r9, xor r9,r9 => r9 = r2 ^ r2
    step(1'b1, {ins(4'h6, 4'h9, 4'h9), ins(4'h1, 4'h2, 4'h9)}, 1'b1, 1'b1, "R5");
    // R6 destination mismatch
    step(1'b1, {ins(4'h3, 4'h5, 4'h8), ins(4'h1, 4'h3, 4'h7)}, 1'b1, 1'b1, "R6");
    // R6 older is ALU, younger is ALU
    step(1'b1, {ins(4'h2, 4'h1, 4'h4), ins(4'h4, 4'h1, 4'h4)}, 1'b1, 1'b1, "R6");
    // R6 younger not ALU (opcode 7)
    step(1'b1, {ins(4'h7, 4'h1, 4'h4), ins(4'h1, 4'h1, 4'h4)}, 1'b1, 1'b1, "R6");
    // R7 younger half invalid
    step(1'b1, {ins(4'h5, 4'h5, 4'h7), ins(4'h1, 4'h3, 4'h7)}, 1'b0, 1'b1, "R7");
    // R8 malformed younger and malformed older
    step(1'b1, {ins(4'h2, 4'h5, 4'h7) | 16'h1, ins(4'h1, 4'h3, 4'h7)}, 1'b1, 1'b1, "R8");
    step(1'b1, {ins(4'h2, 4'h5, 4'h7), ins(4'h1, 4'h3, 4'h7) | 16'h8}, 1'b1, 1'b1, "R8");
    // R2 single ALU, R3 single move, R9 other opcode
    step(1'b1, {16'h0, ins(4'h3, 4'hA, 4'hB)}, 1'b1, 1'b1, "R2");
    step(1'b1, {16'h0, ins(4'h1, 4'hC, 4'hD)}, 1'b1, 1'b1, "R3");
    step(1'b1, {16'h0, ins(4'hE, 4'h2, 4'h6)}, 1'b1, 1'b1, "R9");
    // R10 back-pressure then release
    step(1'b1, {ins(4'h4, 4'h1, 4'h2), ins(4'h1, 4'h0, 4'h2)}, 1'b1, 1'b0, "R4");
    step(1'b1, {16'h0, ins(4'h2, 4'h1, 4'h1)}, 1'b1, 1'b0, "R2");
    step(1'b1, {16'h0, ins(4'h2, 4'h1, 4'h1)}, 1'b1, 1'b0, "R2");
    drain();

    for (int i = 0; i < 4000; i++)
      step($urandom_range(0, 3) != 0, rand_window(), $urandom_range(0, 4) != 0,
           $urandom_range(0, 2) != 0, "");
    drain();
    check("R10", {17'h0, out_valid, 1'b0}, 19'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule